// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block models a single-port synchronous static RAM with a four-beat burst engine and a small internal array. Every command is sampled on the rising clock edge. Either of two address strobes starts an access: the processor-side strobe always reads, and the controller-side strobe reads or writes according to the write inputs. After that, an advance input steps a 2-bit beat counter through the rest of a four-word group. The counter follows a linear order or an interleaved order, chosen by a mode pin. A cycle with neither a strobe nor advance repeats the current word.

Write data is taken from the data-in bus on the same edge as the write command. Read data comes out directly after the command edge in flow-through mode. In pipeline mode it passes through one more register and appears a cycle later. The bidirectional data bus is modelled as data-in, data-out and a drive-enable. A sleep input stops all activity two clock edges after it is first sampled high. Array contents and burst state are kept through sleep.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset, no burst is active. The bus is not driven (`dq_oe`=0), and advance or idle cycles drive nothing until a strobe selects the device.
- R2: The processor strobe (`cpu_stb_n`=0) with the device selected starts a read burst at `addr`, even when `gw_n` or `bw_n` request a write and even when `ctl_stb_n` is also low. The array is left unchanged.
- R3: The controller strobe (`ctl_stb_n`=0, `cpu_stb_n`=1) with the device selected starts a burst at `addr`. It is a write when `gw_n`=0 or any `bw_n` bit is 0, and a read otherwise. Write data is taken from `dq_i` on that same edge.
- R4: The device is selected when `sel_n`=0 and `sel`=1. These are sampled only on strobe edges. A strobe with the device not selected ends the burst, writes nothing and drives nothing. On advance-only cycles, `sel_n` and `sel` have no effect.
- R5: With `gw_n`=0, all bytes are written. Otherwise, byte lane i (`dq_i` bits 8i+7..8i) is written only when `bw_n[i]`=0.
- R6: Each advance cycle (`adv_n`=0, no strobe, burst active) moves the beat count c up by 1, modulo 4. It then accesses the address whose upper bits equal those of the base address and whose low two bits are (base+c) mod 4 when `order_lin`=1, or base XOR c when `order_lin`=0. The operation is read or write per R3's write rule.
- R7: A cycle with both strobes high and `adv_n`=1 while a burst is active repeats the current address. It reads or writes according to the write inputs.
- R8: With `pipe_mode`=0, read data is on `dq_o` in the cycle after the command edge. With `pipe_mode`=1, it appears one cycle later.
- R9: `dq_oe` is 1 only when the output stage holds read data and `oe_n`=0. A read with `oe_n`=1 (dummy read) leaves the bus undriven. An output stage that holds a write, deselect or sleep cycle leaves the bus undriven.
- R10: If `sleep` is sampled high at edge k, commands at edges k+2 onward are ignored and the bus is undriven from just after edge k+1. After `sleep` is sampled low at edge m, commands are accepted again from edge m+2. Array contents and burst position are unchanged across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address loaded by a strobe |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| gw_n | input | 1 | Global write of all bytes, active low |
| bw_n | input | NB | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| pipe_mode | input | 1 | 1 pipeline output, 0 flow-through |
| sleep | input | 1 | Sleep request, active high |
| dq_i | input | NB*BW | Write data |
| dq_o | output | NB*BW | Read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with AW=4, NB=2 and BW=8, which gives a 16-word array of 16-bit words with two byte lanes. At that size every base address can be swept as the start of a five-beat burst that wraps past the group end. The sweep covers both burst orders and both output modes, with each beat checked against a shadow copy of the array. Directed sequences then cover strobe priority, byte-lane masking, deselect and ignored enables, suspend, dummy reads, and the exact edges at which sleep starts and stops blocking commands.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        CY_HOLD,
        CY_START_CPU,
        CY_START_CTL,
        CY_ADVANCE,
        CY_SUSPEND,
        CY_DESEL,
        CY_SLEEP
    } cyc_e;

    typedef struct packed {
        logic       act;
        logic [1:0] cnt;
    } burst_t;

    function automatic logic [1:0] beat_offset(input logic [1:0] base,
                                               input logic [1:0] cnt,
                                               input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/sbsram_sleep.sv
module sbsram_sleep (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    output logic asleep_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            asleep_o <= 1'b0;
        end else begin
            req_q    <= sleep_i;
            asleep_o <= req_q;
        end
    end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          asleep,
    input  logic [AW-1:0] addr,
    input  logic          cpu_stb_n,
    input  logic          ctl_stb_n,
    input  logic          adv_n,
    input  logic          sel_n,
    input  logic          sel,
    input  logic          gw_n,
    input  logic [NB-1:0] bw_n,
    input  logic          order_lin,
    output logic          wr_en,
    output logic [NB-1:0] wr_mask,
    output logic [AW-1:0] acc_addr,
    output logic          rd_fire_q,
    output logic [AW-1:0] rd_addr_q
);
    cyc_e          cyc;
    burst_t        st_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_nx;
    logic          selected;
    logic          wr_req;
    logic          cont_op;
    logic          do_read;

    assign selected = !sel_n && sel;
    assign wr_req   = !gw_n || !(&bw_n);
    assign wr_mask  = gw_n ? ~bw_n : {NB{1'b1}};

    always_comb begin
        cyc = CY_HOLD;
        if (asleep)          cyc = CY_SLEEP;
        else if (!cpu_stb_n) cyc = selected ? CY_START_CPU : CY_DESEL;
        else if (!ctl_stb_n) cyc = selected ? CY_START_CTL : CY_DESEL;
        else if (st_q.act)   cyc = adv_n ? CY_SUSPEND : CY_ADVANCE;
    end

    assign cnt_nx  = (cyc == CY_ADVANCE) ? st_q.cnt + 2'd1 : st_q.cnt;
    assign cont_op = (cyc == CY_START_CTL) || (cyc == CY_ADVANCE) || (cyc == CY_SUSPEND);
    assign wr_en   = cont_op && wr_req;
    assign do_read = (cyc == CY_START_CPU) || (cont_op && !wr_req);

    always_comb begin
        if (cyc == CY_START_CPU || cyc == CY_START_CTL)
            acc_addr = addr;
        else
            acc_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_nx, order_lin)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            base_q    <= '0;
            rd_fire_q <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            case (cyc)
                CY_START_CPU, CY_START_CTL: begin
                    base_q   <= addr;
                    st_q.cnt <= 2'd0;
                    st_q.act <= 1'b1;
                end
                CY_DESEL:   st_q.act <= 1'b0;
                CY_ADVANCE: st_q.cnt <= cnt_nx;
                default: ;
            endcase
            rd_fire_q <= do_read;
            if (do_read) rd_addr_q <= acc_addr;
        end
    end

    // R6: advancing stays inside the four-word group
    a_r6_group_kept: assert property (@(posedge clk) disable iff (rst)
        (!asleep && cpu_stb_n && ctl_stb_n && !adv_n && st_q.act) |=> $stable(base_q));

    // R4: enables have no effect when no strobe is present
    a_r4_ce_ignored: assert property (@(posedge clk) disable iff (rst)
        (!asleep && cpu_stb_n && ctl_stb_n) |=> (st_q.act == $past(st_q.act)));

    // R4: a deselected strobe ends the burst
    a_r4_desel_ends: assert property (@(posedge clk) disable iff (rst)
        (!asleep && !cpu_stb_n && sel_n) |=> !st_q.act);

    // R2: a processor strobe never writes
    a_r2_cpu_reads: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stb_n) |-> !wr_en);
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_mask,
    input  logic [NB*BW-1:0] din,
    input  logic [AW-1:0]    rd_addr,
    output logic [NB*BW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b])
                lane_mem[wr_addr] <= din[b*BW +: BW];
        end

        assign rd_data[b*BW +: BW] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/sbsram_out.sv
module sbsram_out #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_mode,
    input  logic          oe_n,
    input  logic          asleep,
    input  logic          flow_v,
    input  logic [DW-1:0] flow_d,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    logic          pipe_v;
    logic [DW-1:0] pipe_d;
    logic          stage_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_v <= 1'b0;
            pipe_d <= '0;
        end else begin
            pipe_v <= flow_v;
            pipe_d <= flow_d;
        end
    end

    assign stage_v = pipe_mode ? pipe_v : flow_v;
    assign dq_o    = stage_v ? (pipe_mode ? pipe_d : flow_d) : '0;
    assign dq_oe   = stage_v && !oe_n && !asleep;
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             adv_n,
    input  logic             sel_n,
    input  logic             sel,
    input  logic             gw_n,
    input  logic [NB-1:0]    bw_n,
    input  logic             oe_n,
    input  logic             order_lin,
    input  logic             pipe_mode,
    input  logic             sleep,
    input  logic [NB*BW-1:0] dq_i,
    output logic [NB*BW-1:0] dq_o,
    output logic             dq_oe
);
    localparam int DW = NB * BW;

    logic          asleep;
    logic          wr_en;
    logic [NB-1:0] wr_mask;
    logic [AW-1:0] acc_addr;
    logic          rd_fire;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    sbsram_sleep u_sleep (
        .clk      (clk),
        .rst      (rst),
        .sleep_i  (sleep),
        .asleep_o (asleep)
    );

    sbsram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .asleep    (asleep),
        .addr      (addr),
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .adv_n     (adv_n),
        .sel_n     (sel_n),
        .sel       (sel),
        .gw_n      (gw_n),
        .bw_n      (bw_n),
        .order_lin (order_lin),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .acc_addr  (acc_addr),
        .rd_fire_q (rd_fire),
        .rd_addr_q (rd_addr)
    );

    sbsram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (acc_addr),
        .wr_mask (wr_mask),
        .din     (dq_i),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sbsram_out #(.DW(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .asleep    (asleep),
        .flow_v    (rd_fire),
        .flow_d    (rd_data),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );

    // R10: commands seen while asleep start no read
    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        asleep |=> !rd_fire);

    // R10: no array write while asleep
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !wr_en);

    // R8: pipelined data comes from a read one edge older
    a_r8_pipe_lag: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && dq_oe) |-> $past(rd_fire));

    // R9: never drive with output enable high
    a_r9_oe_gate: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !oe_n);
endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int BW = 8;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          cpu_stb_n, ctl_stb_n, adv_n, sel_n, sel, gw_n, oe_n;
    logic [NB-1:0] bw_n;
    logic          order_lin, pipe_mode, sleep;
    logic [DW-1:0] dq_i, dq_o;
    logic          dq_oe;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [DW-1:0] shadow [1 << AW];
    logic          pend_v;
    logic [DW-1:0] pend_d;

    always #5 clk = ~clk;

    burst_sram #(.AW(AW), .NB(NB), .BW(BW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .cpu_stb_n(cpu_stb_n),
        .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .sel_n(sel_n), .sel(sel),
        .gw_n(gw_n), .bw_n(bw_n), .oe_n(oe_n), .order_lin(order_lin),
        .pipe_mode(pipe_mode), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe)
    );

    task automatic check(input logic ev, input logic [DW-1:0] ed, input string tag);
        bit ok;
        total++;
        ok = ev ? (dq_oe === 1'b1 && dq_o === ed) : (dq_oe === 1'b0);
        if (!ok) begin
            fails++;
            $display("FAIL %s: got oe=%0b data=%h, expected oe=%0b data=%h",
                     tag, dq_oe, dq_o, ev, ed);
        end
    endtask

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
        sel_n = 1'b0; sel = 1'b1; gw_n = 1'b1; bw_n = '1; oe_n = 1'b0;
    endtask

    // one edge; expectation is for the command set up before it
    task automatic tick(input logic ev, input logic [DW-1:0] ed, input string tag);
        @(posedge clk);
        #3;
        if (!pipe_mode) check(ev, ed, tag);
        else check(pend_v, pend_d, tag);
        pend_v = ev;
        pend_d = ed;
    endtask

    task automatic desel_tick(input string tag);
        idle();
        cpu_stb_n = 1'b0; sel_n = 1'b1;
        tick(1'b0, '0, tag);
        idle();
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int c, input logic lin);
        logic [1:0] lo;
        lo = lin ? 2'((int'(b[1:0]) + c) % 4) : (b[1:0] ^ 2'(c));
        return {b[AW-1:2], lo};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        idle();
        addr = '0; order_lin = 1'b1; pipe_mode = 1'b0; sleep = 1'b0; dq_i = '0;
        pend_v = 1'b0; pend_d = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #3 rst = 1'b0;

        // R1: quiet after reset, advance alone does nothing
        check(1'b0, '0, "R1 reset");
        adv_n = 1'b0;
        tick(1'b0, '0, "R1 advance after reset");
        idle();
        tick(1'b0, '0, "R1 idle after reset");

        // R3/R5: fill with controller strobe, global write
        for (int a = 0; a < (1 << AW); a++) begin
            idle();
            ctl_stb_n = 1'b0; gw_n = 1'b0; addr = AW'(a);
            dq_i = DW'((a * 16'h1111) ^ 16'h5A3C);
            shadow[a] = dq_i;
            tick(1'b0, '0, "R3 write start undriven");
        end
        desel_tick("R9 deselect");

        // R2/R8: flow-through reads of every word, write inputs asserted
        for (int a = 0; a < (1 << AW); a++) begin
            idle();
            cpu_stb_n = 1'b0; gw_n = 1'b0; bw_n = '0; addr = AW'(a); dq_i = 16'hDEAD;
            tick(1'b1, shadow[a], "R2 cpu read");
        end
        desel_tick("R4 deselect");

        // R6/R8: burst sweep, both orders and both output modes
        for (int pm = 0; pm < 2; pm++) begin
            for (int ln = 0; ln < 2; ln++) begin
                pipe_mode = pm[0]; order_lin = ln[0];
                pend_v = 1'b0;
                for (int b = 0; b < (1 << AW); b++) begin
                    idle();
                    cpu_stb_n = 1'b0; addr = AW'(b);
                    tick(1'b1, shadow[b], "R8 burst start");
                    idle();
                    adv_n = 1'b0;
                    for (int c = 1; c <= 4; c++)
                        tick(1'b1, shadow[beat_addr(AW'(b), c, ln[0])], "R6 beat");
                    desel_tick("R8 pipeline tail");
                end
            end
        end
        pipe_mode = 1'b0; order_lin = 1'b1; pend_v = 1'b0;

        // R5: byte lanes
        idle(); ctl_stb_n = 1'b0; addr = 4'd3; bw_n = 2'b10; dq_i = 16'hABCD;
        shadow[3][7:0] = 8'hCD;
        tick(1'b0, '0, "R5 low lane write");
        idle(); ctl_stb_n = 1'b0; addr = 4'd4; bw_n = 2'b01; dq_i = 16'h1234;
        shadow[4][15:8] = 8'h12;
        tick(1'b0, '0, "R5 high lane write");
        idle(); ctl_stb_n = 1'b0; addr = 4'd9; gw_n = 1'b0; bw_n = 2'b10; dq_i = 16'h7788;
        shadow[9] = 16'h7788;
        tick(1'b0, '0, "R5 global overrides");
        idle(); cpu_stb_n = 1'b0; addr = 4'd3; tick(1'b1, shadow[3], "R5 low lane read");
        idle(); cpu_stb_n = 1'b0; addr = 4'd4; tick(1'b1, shadow[4], "R5 high lane read");
        idle(); cpu_stb_n = 1'b0; addr = 4'd9; tick(1'b1, shadow[9], "R5 global read");

        // R2: both strobes with write request -> read, no write
        idle(); cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; gw_n = 1'b0; addr = 4'd5; dq_i = 16'h0BAD;
        tick(1'b1, shadow[5], "R2 priority read");
        idle(); cpu_stb_n = 1'b0; addr = 4'd5;
        tick(1'b1, shadow[5], "R2 array unchanged");

        // R3: controller strobe without write request reads
        idle(); ctl_stb_n = 1'b0; addr = 4'd7;
        tick(1'b1, shadow[7], "R3 ctl read");

        // R4: enables ignored during advance
        idle(); cpu_stb_n = 1'b0; addr = 4'd8;
        tick(1'b1, shadow[8], "R4 start");
        idle(); adv_n = 1'b0; sel_n = 1'b1; sel = 1'b0;
        tick(1'b1, shadow[9], "R4 advance ignores enables");

        // R4: deselected controller write does nothing
        idle(); ctl_stb_n = 1'b0; sel = 1'b0; gw_n = 1'b0; addr = 4'd10; dq_i = 16'hFFFF;
        tick(1'b0, '0, "R4 deselected write");
        idle(); adv_n = 1'b0;
        tick(1'b0, '0, "R4 no burst after deselect");
        idle(); cpu_stb_n = 1'b0; addr = 4'd10;
        tick(1'b1, shadow[10], "R4 no write when deselected");

        // R6/R3: burst write through advance, linear from 6
        idle(); ctl_stb_n = 1'b0; gw_n = 1'b0; addr = 4'd6; dq_i = 16'hA006; shadow[6] = dq_i;
        tick(1'b0, '0, "R3 burst write start");
        for (int c = 1; c < 4; c++) begin
            idle(); adv_n = 1'b0; gw_n = 1'b0; dq_i = DW'(16'hA100 + c);
            shadow[beat_addr(4'd6, c, 1'b1)] = dq_i;
            tick(1'b0, '0, "R6 write beat");
        end
        for (int a = 4; a < 8; a++) begin
            idle(); cpu_stb_n = 1'b0; addr = AW'(a);
            tick(1'b1, shadow[a], "R6 burst write readback");
        end

        // R7: suspend repeats the address
        idle(); cpu_stb_n = 1'b0; addr = 4'd1;
        tick(1'b1, shadow[1], "R7 start");
        idle();
        tick(1'b1, shadow[1], "R7 suspend read");
        idle(); gw_n = 1'b0; dq_i = 16'h5151; shadow[1] = dq_i;
        tick(1'b0, '0, "R7 suspend write");
        idle(); cpu_stb_n = 1'b0; addr = 4'd1;
        tick(1'b1, shadow[1], "R7 suspend write readback");

        // R9: dummy read
        idle(); cpu_stb_n = 1'b0; addr = 4'd2; oe_n = 1'b1;
        tick(1'b0, '0, "R9 dummy read");
        desel_tick("R9 after dummy");

        // R10: sleep entry and exit timing, state kept
        idle(); cpu_stb_n = 1'b0; addr = 4'd12; sleep = 1'b1;
        tick(1'b1, shadow[12], "R10 edge k accepted");
        idle(); adv_n = 1'b0;
        tick(1'b0, '0, "R10 bus off after k+1");
        for (int i = 0; i < 2; i++) begin
            idle(); ctl_stb_n = 1'b0; gw_n = 1'b0; addr = 4'd2; dq_i = 16'hEEEE;
            tick(1'b0, '0, "R10 asleep ignores write");
        end
        sleep = 1'b0;
        for (int i = 0; i < 2; i++) begin
            idle(); adv_n = 1'b0;
            tick(1'b0, '0, "R10 still blocked");
        end
        idle(); adv_n = 1'b0;
        tick(1'b1, shadow[14], "R10 burst position kept");
        idle(); cpu_stb_n = 1'b0; addr = 4'd2;
        tick(1'b1, shadow[2], "R10 array kept");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule